// File: doc/BRIEF.md
# Keyed Option-Word Write Controller

This block guards a persistent configuration word behind its own two-word key and lock bit, kept apart from any main memory lock. Software reaches it through a small register-mapped write port and a combinational read port. After the lock is released with the correct key pair, software writes a new configuration value to the option-control register. It then writes the value again with the start bit set. The controller strips the reserved bits, raises busy for a fixed programming time and only then commits the value to the shadow register that the rest of the chip reads. Software finally writes the lock bit to close the register again.

Only one value is ever committed at a time. The visible configuration word stays at its old value for the whole programming window and changes in the single cycle in which busy falls. A start issued while the register is locked, or while a previous programming operation is still running, is dropped and sets a sticky error flag. Writing one to that flag clears it.

Top module: `opt_word_ctrl`

## Requirements
- R1: After synchronous reset the lock bit is 1, busy and error are 0, and both the committed word and the staged value are 0x0FFFAAEC (the factory word 0x0FFFAAED with the reserved bits cleared). A control read (address 2) therefore returns 0x0FFFAAED, and a status read (address 0) returns 0.
- R2: Writing 0x08192A3B and then 0x4C5D6E7F to the key register (address 1) on consecutive key writes clears the lock bit (control bit 0).
- R3: A second key word without the first, or any other key write between the two key words, leaves the lock bit set.
- R4: While locked, control writes that do not start programming leave the staged value unchanged.
- R5: A control write with start (bit 1) set while locked does not raise busy, leaves the committed word unchanged and sets the error flag (status bit 1).
- R6: An unlocked control write with bits 0 and 1 clear stores the written value with the reserved mask 0xF0000013 cleared as the staged value. It does not start programming and does not change the committed word.
- R7: An unlocked, idle control write with start set and lock clear raises busy (status bit 16, also control bit 1) for exactly PROG_CYCLES clock cycles.
- R8: The committed word keeps its previous value while busy is high and takes the staged value in the cycle busy falls.
- R9: Reserved bits under mask 0xF0000013 never reach the committed word. Starting with 0xFFFFFFFE commits 0x0FFFFFEC.
- R10: A control write with start set while busy is ignored, sets the error flag and does not alter the value being committed.
- R11: An unlocked control write with bit 0 set sets the lock again and ignores every other bit of that write. The lock bit is never set while busy.
- R12: Writing a 1 to status bit 1 clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address: 0 status, 1 key, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rd_addr | input | 2 | Read address |
| bus_rdata | output | 32 | Read data for bus_rd_addr (combinational) |
| cfg_word | output | 32 | Committed configuration word |
| busy | output | 1 | Programming in progress |

## Verification
The key register is driven with the correct pair, with the second word alone, and with the pair broken by a stray word. Only the correct pair may release the lock. Control writes are tried while locked, unlocked without start, unlocked with start, with start while busy, and with the lock bit set. These cases separate staging from programming and from the ignored paths. An all-ones value and the factory word are committed and compared by a scoreboard against the expected masked words. The scoreboard tells an unmasked or early commit apart from a correct one, and the busy window is counted cycle by cycle.

// File: rtl/opt_cfg_pkg.sv
package opt_cfg_pkg;

    localparam logic [31:0] KEY_FIRST    = 32'h08192A3B;
    localparam logic [31:0] KEY_SECOND   = 32'h4C5D6E7F;
    localparam logic [31:0] RSVD_MASK    = 32'hF0000013;
    localparam logic [31:0] FACTORY_WORD = 32'h0FFFAAED;

    localparam int LOCK_BIT  = 0;
    localparam int START_BIT = 1;
    localparam int ERR_BIT   = 1;
    localparam int BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_KEY  = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_HALF = 1'b1
    } key_state_e;

    typedef struct packed {
        logic        lock;
        logic        err;
        logic [31:0] staged;
        logic [31:0] committed;
    } opt_state_t;

    function automatic logic [31:0] scrub(input logic [31:0] v);
        return v & ~RSVD_MASK;
    endfunction

endpackage

// File: rtl/opt_key_seq.sv
module opt_key_seq
    import opt_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    input  logic        armed,
    output logic        unlock
);

    key_state_e state_q;

    assign unlock = armed && key_wr && (state_q == KS_HALF) && (key_data == KEY_SECOND);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            state_q <= KS_IDLE;
        end else if (key_wr) begin
            state_q <= (key_data == KEY_FIRST) ? KS_HALF : KS_IDLE;
        end
    end

endmodule

// File: rtl/opt_prog_timer.sv
module opt_prog_timer #(
    parameter int PROG_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(PROG_CYCLES);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic [CW-1:0] cnt_q;

    assign done = busy && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (load && !busy) begin
            busy  <= 1'b1;
            cnt_q <= LOAD_VAL;
        end else if (busy) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/opt_word_ctrl.sv
module opt_word_ctrl
    import opt_cfg_pkg::*;
#(
    parameter int PROG_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [1:0]  bus_rd_addr,
    output logic [31:0] bus_rdata,
    output logic [31:0] cfg_word,
    output logic        busy
);

    opt_state_t st_q, st_d;
    logic wr_key, wr_ctrl, wr_stat;
    logic unlock, start_ok, start_bad, done;

    assign wr_key  = bus_wr && (reg_sel_e'(bus_addr) == REG_KEY);
    assign wr_ctrl = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
    assign wr_stat = bus_wr && (reg_sel_e'(bus_addr) == REG_STAT);

    assign start_ok  = wr_ctrl && !st_q.lock && !busy
                       && bus_wdata[START_BIT] && !bus_wdata[LOCK_BIT];
    assign start_bad = wr_ctrl && bus_wdata[START_BIT] && (st_q.lock || busy);

    opt_key_seq u_keys (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (wr_key),
        .key_data (bus_wdata),
        .armed    (st_q.lock),
        .unlock   (unlock)
    );

    opt_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (start_ok),
        .busy (busy),
        .done (done)
    );

    always_comb begin
        st_d = st_q;
        if (unlock) st_d.lock = 1'b0;
        if (wr_ctrl && !st_q.lock && !busy) begin
            if (bus_wdata[LOCK_BIT]) st_d.lock = 1'b1;
            else                     st_d.staged = scrub(bus_wdata);
        end
        if (wr_stat && bus_wdata[ERR_BIT]) st_d.err = 1'b0;
        if (start_bad) st_d.err = 1'b1;
        if (done) st_d.committed = st_q.staged;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lock      <= 1'b1;
            st_q.err       <= 1'b0;
            st_q.staged    <= scrub(FACTORY_WORD);
            st_q.committed <= scrub(FACTORY_WORD);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_word = st_q.committed;

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_rd_addr))
            REG_STAT: begin
                bus_rdata[BUSY_BIT] = busy;
                bus_rdata[ERR_BIT]  = st_q.err;
            end
            REG_CTRL: begin
                bus_rdata = st_q.staged;
                bus_rdata[LOCK_BIT]  = st_q.lock;
                bus_rdata[START_BIT] = busy;
            end
            default: bus_rdata = '0;
        endcase
    end

    int unsigned busy_len_q;
    always_ff @(posedge clk) begin
        if (rst || !busy) busy_len_q <= 0;
        else              busy_len_q <= busy_len_q + 1;
    end

    // R2
    key_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        unlock |=> !st_q.lock);

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.lock && !unlock) |=> $stable(st_q.staged));

    // R5
    locked_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && bus_wdata[START_BIT] && st_q.lock) |=> (st_q.err && !busy));

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len_q == PROG_CYCLES));

    // R8
    commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(cfg_word));

    // R9
    rsvd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_word & RSVD_MASK) == 32'h0);

    // R11
    lock_idle_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.lock |-> !busy);

endmodule

// File: tb/tb_opt_word_ctrl.sv
`timescale 1ns/1ps
module tb_opt_word_ctrl;

    localparam int PROG_CYCLES = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_rd_addr = 2'd0;
    logic [31:0] bus_rdata;
    logic [31:0] cfg_word;
    logic        busy;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [31:0] exp_q[$];
    logic [31:0] last_cfg;

    always #2.5 clk = ~clk;

    opt_word_ctrl #(.PROG_CYCLES(PROG_CYCLES)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rd_addr(bus_rd_addr), .bus_rdata(bus_rdata),
        .cfg_word(cfg_word), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // waits for busy to drop; returns busy length, flags early commit
    task automatic wait_idle(input string req, output int n);
        logic [31:0] hold;
        bit early;
        hold = cfg_word; early = 0; n = 0;
        while (busy === 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
            if (busy === 1'b1 && cfg_word !== hold) early = 1;
        end
        chk(req, {31'b0, early}, 32'd0);
    endtask

    // scoreboard monitor: every change of the committed word pops one expectation
    initial begin
        forever begin
            @(negedge clk);
            if (rst) last_cfg = cfg_word;
            else if (cfg_word !== last_cfg) begin
                if (exp_q.size() == 0) chk("R8 unexpected commit", cfg_word, last_cfg);
                else chk("R8/R9 commit", cfg_word, exp_q.pop_front());
                last_cfg = cfg_word;
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1
        chk("R1 cfg", cfg_word, 32'h0FFFAAEC);
        rd(2'd2, v); chk("R1 ctrl", v, 32'h0FFFAAED);
        rd(2'd0, v); chk("R1 stat", v, 32'h0);
        chk("R1 busy", {31'b0, busy}, 32'd0);

        // R4 locked write ignored
        wr(2'd2, 32'h12345678);
        rd(2'd2, v); chk("R4 locked write", v, 32'h0FFFAAED);

        // R3 bad key sequences
        wr(2'd1, 32'h4C5D6E7F);
        rd(2'd2, v); chk("R3 second key alone", v & 32'h1, 32'h1);
        wr(2'd1, 32'h08192A3B); wr(2'd1, 32'hDEADBEEF); wr(2'd1, 32'h4C5D6E7F);
        rd(2'd2, v); chk("R3 broken pair", v & 32'h1, 32'h1);

        // R5 start while locked
        wr(2'd2, 32'h00000002);
        rd(2'd0, v); chk("R5 error no busy", v, 32'h00000002);
        chk("R5 cfg", cfg_word, 32'h0FFFAAEC);

        // R12 clear error
        wr(2'd0, 32'h00000002);
        rd(2'd0, v); chk("R12 error cleared", v, 32'h0);

        // R2 unlock
        wr(2'd1, 32'h08192A3B); wr(2'd1, 32'h4C5D6E7F);
        rd(2'd2, v); chk("R2 unlocked", v, 32'h0FFFAAEC);

        // R6 stage only
        wr(2'd2, 32'hF0ABCD10);
        rd(2'd2, v); chk("R6 staged masked", v, 32'h00ABCD00);
        chk("R6 no busy", {31'b0, busy}, 32'd0);
        chk("R6 cfg unchanged", cfg_word, 32'h0FFFAAEC);

        // R7 R8 R9 full commit of all ones
        exp_q.push_back(32'h0FFFFFEC);
        wr(2'd2, 32'hFFFFFFFE);
        rd(2'd0, v); chk("R7 status busy", v, 32'h00010000);
        rd(2'd2, v); chk("R7 ctrl busy", v, 32'h0FFFFFEE);
        wait_idle("R8 no early commit", n);
        chk("R7 busy length", n, PROG_CYCLES);
        @(negedge clk);
        chk("R9 masked commit", cfg_word, 32'h0FFFFFEC);

        // R10 start while busy
        exp_q.push_back(32'h00ABCD00);
        wr(2'd2, 32'h00ABCD02);
        wr(2'd2, 32'h11111102);
        rd(2'd0, v); chk("R10 busy and error", v, 32'h00010002);
        wait_idle("R8 no early commit 2", n);
        @(negedge clk);
        chk("R10 commit unaffected", cfg_word, 32'h00ABCD00);
        rd(2'd2, v); chk("R10 staged kept", v, 32'h00ABCD00);
        wr(2'd0, 32'h00000002);

        // R11 relock ignores other bits
        wr(2'd2, 32'h00000FF1);
        rd(2'd2, v); chk("R11 relocked", v, 32'h00ABCD01);
        chk("R11 no busy", {31'b0, busy}, 32'd0);

        // restore factory word
        wr(2'd1, 32'h08192A3B); wr(2'd1, 32'h4C5D6E7F);
        exp_q.push_back(32'h0FFFAAEC);
        wr(2'd2, 32'h0FFFAAEE);
        wait_idle("R8 no early commit 3", n);
        @(negedge clk);
        chk("R9 factory restore", cfg_word, 32'h0FFFAAEC);
        wr(2'd2, 32'h00000001);
        rd(2'd2, v); chk("R11 final lock", v & 32'h1, 32'h1);

        repeat (2) @(negedge clk);
        chk("R8 scoreboard drained", exp_q.size(), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule